// File: doc/BRIEF.md
# Output Compare Carrier Modulator

This block merges two timer waveforms onto a single output pin, a typical arrangement for infrared transmitters. A fast PWM counter with one compare channel produces the modulating signal. A second counter runs in clear-on-match mode and toggles its output on every match, which makes a square-wave carrier. A gate then joins the two signals with logical AND or logical OR. A polarity bit picks which of the two is used. A separate direction bit alone decides whether the pin driver is enabled.

Software programs the block through a small synchronous write port. The port has four word registers: the PWM period limit, the PWM compare value, the carrier match value and a control word. The pin value and the pin enable are both registered. The combining gate therefore adds exactly one clock of latency, whichever gate is selected.

When the carrier is a two-clock square wave and the AND gate is selected, PWM high times that differ by one clock can give the same pin waveform. The resolution seen at the pin is divided by the carrier period in clocks.

Top module: `ocm_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pin_o` and `pin_oe_o` are 0. Every register clears to 0.
- R2: With `mod_en` (control bit 0) at 0, `pin_o` follows the raw PWM signal. A running PWM counter counts 0..TOP and then wraps, so one period lasts TOP+1 clocks. The PWM signal is 1 while the count is below the active compare value. A compare value of 0 keeps the pin low, and a value above TOP keeps it high.
- R3: A write to the PWM compare register (address 1) lands in a shadow copy. The active compare value loads from that copy only on the clock where the count is at TOP, or while the PWM counter is stopped.
- R4: With the carrier mode field (control bits 6:5) equal to 1, the carrier toggles each time its counter passes its match value (address 2). It starts from 0, so its period is 2*(match+1) clocks. With any other mode value the carrier holds its level.
- R5: With `mod_en`=1 and polarity (control bit 1) equal to 0, `pin_o` is the AND of the PWM signal and the carrier.
- R6: With `mod_en`=1 and polarity equal to 1, `pin_o` is the OR of the PWM signal and the carrier.
- R7: `pin_oe_o` equals the direction bit (control bit 2), one clock later. The mode field, polarity and `mod_en` have no effect on it.
- R8: `pin_o` reflects the counter and control state one clock after that state, for both the AND and the OR selection.
- R9: With TOP=7, a carrier match of 0 and AND selected, compare values 4 and 5 give the same 8-clock pin pattern.
- R10: When the run bit of a counter is 0 (bit 3 for PWM, bit 4 for the carrier), that counter is held at 0. A stopped carrier is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 PWM TOP, 1 PWM compare, 2 carrier match, 3 control |
| wr_data | input | W | Write data |
| pin_o | output | 1 | Registered modulated pin value |
| pin_oe_o | output | 1 | Registered pin driver enable |

## Verification
Two events can fall on the same edge: a write to the PWM compare shadow, and the TOP wrap that copies the shadow into the active compare. In that case the old shadow value is copied, so the new value waits a full period. A carrier toggle can also coincide with a PWM edge, where the gate output depends on both new values at once. Random writes with random waits land on these edges many times, and directed phases force the two-clock carrier against an even period. A cycle model in the bench, built from the requirements, judges every cycle's pin value and enable.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_PWM_TOP = 2'd0;
  localparam logic [ADDR_W-1:0] A_PWM_CMP = 2'd1;
  localparam logic [ADDR_W-1:0] A_CAR_TOP = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd3;
  localparam logic [1:0] CAR_TOGGLE = 2'd1;

  typedef struct packed {
    logic [1:0] car_mode; // 6:5
    logic       car_run;  // 4
    logic       pwm_run;  // 3
    logic       dir;      // 2
    logic       pol;      // 1
    logic       mod_en;   // 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ocm_regs.sv
module ocm_regs
  import ocm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      pwm_top,
  output logic [W-1:0]      pwm_cmp_shadow,
  output logic [W-1:0]      car_top,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_top        <= '0;
      pwm_cmp_shadow <= '0;
      car_top        <= '0;
      ctrl           <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PWM_TOP: pwm_top        <= wr_data;
        A_PWM_CMP: pwm_cmp_shadow <= wr_data;
        A_CAR_TOP: car_top        <= wr_data;
        default:   ctrl           <= ctrl_t'(wr_data[CTRL_W-1:0]);
      endcase
    end
  end
endmodule

// File: rtl/ocm_pwm.sv
module ocm_pwm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] top,
  input  logic [W-1:0] cmp_shadow,
  output logic         pwm_o,
  output logic         at_top_o,
  output logic [W-1:0] cmp_act_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cmp_q;

  assign at_top_o  = run && (cnt_q >= top);
  assign pwm_o     = cnt_q < cmp_q;
  assign cmp_act_o = cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      cmp_q <= cmp_shadow;
    end else if (cnt_q >= top) begin
      cnt_q <= '0;
      cmp_q <= cmp_shadow;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ocm_car.sv
module ocm_car
  import ocm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [1:0]   mode,
  input  logic [W-1:0] top,
  output logic         car_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         car_q;

  assign wrap_o = run && (cnt_q >= top);
  assign car_o  = car_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      car_q <= 1'b0;
    end else if (cnt_q >= top) begin
      cnt_q <= '0;
      if (mode == CAR_TOGGLE) car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ocm_mix.sv
module ocm_mix (
  input  logic clk,
  input  logic rst,
  input  logic mod_en,
  input  logic pol,
  input  logic dir,
  input  logic pwm,
  input  logic car,
  output logic pin_o,
  output logic oe_o
);
  logic gate_w;

  always_comb begin
    if (!mod_en)  gate_w = pwm;
    else if (pol) gate_w = pwm | car;
    else          gate_w = pwm & car;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      pin_o <= gate_w;
      oe_o  <= dir;
    end
  end
endmodule

// File: rtl/ocm_top.sv
module ocm_top
  import ocm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              pin_o,
  output logic              pin_oe_o
);
  logic [W-1:0] pwm_top_w, pwm_shadow_w, car_top_w, cmp_act_w;
  ctrl_t        ctrl_w;
  logic         pwm_w, pwm_at_top_w, car_w, car_wrap_w;

  ocm_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_top(pwm_top_w), .pwm_cmp_shadow(pwm_shadow_w), .car_top(car_top_w),
    .ctrl(ctrl_w)
  );

  ocm_pwm #(.W(W)) u_pwm (
    .clk(clk), .rst(rst), .run(ctrl_w.pwm_run), .top(pwm_top_w),
    .cmp_shadow(pwm_shadow_w), .pwm_o(pwm_w), .at_top_o(pwm_at_top_w),
    .cmp_act_o(cmp_act_w)
  );

  ocm_car #(.W(W)) u_car (
    .clk(clk), .rst(rst), .run(ctrl_w.car_run), .mode(ctrl_w.car_mode),
    .top(car_top_w), .car_o(car_w), .wrap_o(car_wrap_w)
  );

  ocm_mix u_mix (
    .clk(clk), .rst(rst), .mod_en(ctrl_w.mod_en), .pol(ctrl_w.pol),
    .dir(ctrl_w.dir), .pwm(pwm_w), .car(car_w), .pin_o(pin_o), .oe_o(pin_oe_o)
  );
endmodule

// File: rtl/ocm_chk.sv
module ocm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         pwm,
  input logic         car,
  input logic         mod_en,
  input logic         pol,
  input logic         dir,
  input logic         pwm_run,
  input logic         car_run,
  input logic         pwm_at_top,
  input logic         car_wrap,
  input logic [W-1:0] cmp_act,
  input logic         pin,
  input logic         oe
);
  a_r2_plain: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> pin == $past(pwm));
  a_r5_and_low: assert property (@(posedge clk) disable iff (rst)
    (mod_en && !pol && !(pwm && car)) |=> !pin);
  a_r6_or_high: assert property (@(posedge clk) disable iff (rst)
    (mod_en && pol && (pwm || car)) |=> pin);
  a_r7_oe_dir: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> oe == $past(dir));
  a_r4_car_hold: assert property (@(posedge clk) disable iff (rst)
    (car_run && !car_wrap) |=> $stable(car));
  a_r3_cmp_hold: assert property (@(posedge clk) disable iff (rst)
    (pwm_run && !pwm_at_top) |=> $stable(cmp_act));
  a_r10_car_stop: assert property (@(posedge clk) disable iff (rst)
    !car_run |=> !car);
endmodule

bind ocm_top ocm_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .pwm(pwm_w), .car(car_w), .mod_en(ctrl_w.mod_en),
  .pol(ctrl_w.pol), .dir(ctrl_w.dir), .pwm_run(ctrl_w.pwm_run),
  .car_run(ctrl_w.car_run), .pwm_at_top(pwm_at_top_w), .car_wrap(car_wrap_w),
  .cmp_act(cmp_act_w), .pin(pin_o), .oe(pin_oe_o)
);

// File: tb/ocm_top_tb.sv
module ocm_top_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pin_o, pin_oe_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit chk_on = 1'b0;
  string ctx = "";

  always #5 clk = ~clk;

  ocm_top #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  // reference model state, derived from the requirements
  logic [W-1:0] m_top, m_shadow, m_cact, m_cnt, m_ctop, m_ccnt;
  logic [6:0]   m_ctrl;
  logic         m_car, m_pin, m_oe;

  function automatic logic gate_f(logic [6:0] c, logic p, logic k);
    if (!c[0]) return p;
    return c[1] ? (p | k) : (p & k);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_top = '0; m_shadow = '0; m_cact = '0; m_cnt = '0;
      m_ctop = '0; m_ccnt = '0; m_ctrl = '0; m_car = 1'b0;
      m_pin = 1'b0; m_oe = 1'b0;
    end else begin
      m_pin = gate_f(m_ctrl, m_cnt < m_cact, m_car);
      m_oe  = m_ctrl[2];
      if (!m_ctrl[3] || m_cnt >= m_top) begin
        m_cnt = '0; m_cact = m_shadow;
      end else m_cnt = m_cnt + 1'b1;
      if (!m_ctrl[4]) begin
        m_ccnt = '0; m_car = 1'b0;
      end else if (m_ccnt >= m_ctop) begin
        m_ccnt = '0;
        if (m_ctrl[6:5] == 2'd1) m_car = ~m_car;
      end else m_ccnt = m_ccnt + 1'b1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_top = wr_data;
          2'd1: m_shadow = wr_data;
          2'd2: m_ctop = wr_data;
          default: m_ctrl = wr_data[6:0];
        endcase
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // continuous per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      string tag;
      if (ctx != "") tag = ctx;
      else if (!m_ctrl[0]) tag = "R2";
      else tag = m_ctrl[1] ? "R6" : "R5";
      check({tag, " R8 pin"}, pin_o, m_pin);
      check("R7 oe", pin_oe_o, m_oe);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] pat_a, pat_b;

  initial begin
    void'($urandom(32'h0C0FFEE));
    idle(3);
    // R1: reset state
    check("R1 pin in reset", pin_o, 1'b0);
    check("R1 oe in reset", pin_oe_o, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pin after reset", pin_o, 1'b0);
    check("R1 oe after reset", pin_oe_o, 1'b0);
    chk_on = 1'b1;

    // R2: plain PWM, several compare values including 0 and above TOP
    ctx = "R2";
    wr(2'd0, 8'd9);
    foreach (pat_a[i]) begin
      logic [W-1:0] c;
      c = (i == 0) ? 8'd0 : (i == 1) ? 8'd12 : 8'(i + 1);
      wr(2'd3, 8'h00);
      wr(2'd1, c);
      wr(2'd3, 8'h0C); // pwm_run + dir
      idle(25);
    end

    // R3: shadow write mid-period and at the wrap edge
    ctx = "R3";
    wr(2'd1, 8'd3);
    idle(5);
    wr(2'd1, 8'd7);
    idle(20);
    for (int k = 0; k < 12; k++) begin
      wr(2'd1, 8'(k % 11));
      idle(k);
    end

    // R4: carrier seen through OR with a silent PWM, toggle mode then hold mode
    ctx = "R4";
    wr(2'd3, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd2);
    wr(2'd3, 8'h3F); // mode 1, both run, dir, OR, mod_en
    idle(30);
    wr(2'd3, 8'h5F); // mode 2: carrier holds
    idle(20);

    // R10: stopping the carrier forces it low
    ctx = "R10";
    wr(2'd3, 8'h2F);
    idle(10);

    // R9: two-clock carrier, AND, compare 4 vs 5
    ctx = "R9";
    wr(2'd3, 8'h00);
    wr(2'd0, 8'd7);
    wr(2'd2, 8'd0);
    wr(2'd1, 8'd4);
    wr(2'd3, 8'h3D);
    idle(16);
    for (int i = 0; i < 8; i++) begin @(negedge clk); pat_a[i] = pin_o; end
    wr(2'd3, 8'h00);
    wr(2'd1, 8'd5);
    wr(2'd3, 8'h3D);
    idle(16);
    for (int i = 0; i < 8; i++) begin @(negedge clk); pat_b[i] = pin_o; end
    total++;
    if (pat_a !== pat_b) begin
      bad++;
      $display("FAIL R9: actual=%b expected=%b", pat_b, pat_a);
    end
    check("R9 nonzero pattern", |pat_a, 1'b1);

    // R5/R6/R7: random mix of control, compare and periods
    ctx = "";
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4) wr(2'd3, 8'($urandom_range(0, 127)) | 8'h18);
      else if (r < 7) wr(2'd1, 8'($urandom_range(0, 12)));
      else if (r < 8) wr(2'd0, 8'($urandom_range(1, 10)));
      else if (r < 9) wr(2'd2, 8'($urandom_range(0, 3)));
      else wr(2'd3, 8'($urandom_range(0, 127)));
      idle($urandom_range(0, 12));
    end

    chk_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule